// File: doc/BRIEF.md
# Write Status Word Generator

This block forms the word a host sees when it reads the flash while an internal program or erase runs or has been suspended. Three status bits are built from a small amount of state. Bit 7 is a completion poll: during a program it is the inverse of the bit being written, and during an erase it reads low. Bit 6 is a toggle that flips on each read while the device is busy. Bit 2 is a second toggle. It flips only for reads that touch an erase in progress, so software can tell an active erase from a suspended one. When the device is idle, and when a suspended device is read outside the suspended region, the array word passes through unchanged.

Each read is marked by a rising edge of the read strobe. At that clock edge the block captures one status word and advances its toggle state. The returned word therefore stays constant for the whole read, however long the strobe is held. A region is a group of addresses that share all bits above `SECT_LSB`. The array and the erase engine live outside the block. They only supply the busy flag, the operation type, the suspend flag and the suspended address.

Top module: `write_status_gen`

## Requirements
- R1: A synchronous active-high reset clears `status_q` to 0 and clears both toggle states, so the first bit-6 value of a new operation is 0.
- R2: A read while idle (`busy`=0, `erase_susp`=0) returns `arr_data` unchanged in `status_q`.
- R3: A read during a program (`busy`=1, `op_erase`=0) returns bit 7 as the inverse of `pgm_data[7]`, with bits other than 7 and 6 at 0.
- R4: A read during an active erase (`busy`=1, `op_erase`=1) returns bit 7 as 0, with bits other than 7, 6 and 2 at 0.
- R5: In both busy modes, bit 6 returns the current toggle value and the toggle then inverts, so successive reads alternate 0,1,0,...
- R6: During an active erase, bit 2 alternates on every read. During a program, bit 2 reads 0 and its toggle is not advanced.
- R7: When suspended and not busy, a read whose address lies in the suspended region (address bits above `SECT_LSB` equal) returns bit 7 = 1, bit 6 = 1, bit 2 = the erase toggle (which then inverts), and all other bits 0.
- R8: When suspended and not busy, a read outside the suspended region returns `arr_data` and leaves both toggles unchanged. This shows in the bit-2 sequence of the next in-region read.
- R9: A program launched while suspended (`busy`=1, `op_erase`=0, `erase_susp`=1) reports program status for any read address, with bit 6 toggling.
- R10: `status_q` changes only on the clock edge that sees a rising edge of `rd_stb`. Holding the strobe high, or idle cycles, leave it unchanged.
- R11: Any clock with the device idle clears both toggles. The first read after an operation ends returns true data, and the next operation's first bit-6 value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe; a rising edge marks one read |
| rd_addr | input | AW | Word address of the read |
| arr_data | input | DW | True array contents at `rd_addr` |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | Operation type: 1 erase, 0 program |
| pgm_data | input | DW | Word being programmed |
| erase_susp | input | 1 | An erase is suspended |
| susp_addr | input | AW | Address inside the suspended region |
| status_q | output | DW | Word returned for the last read |

## Verification
The interesting collision is a read edge landing on the same clock as a change of mode. Examples are the busy counter reaching zero, a suspend being entered, or an in-suspend program being launched. In that clock, the captured word and the toggle update must both follow the inputs present at that edge, and the idle clear must win over any flip. The bench provokes this by changing busy, suspend and operation type together with the strobe rise, both in directed steps and in a random walk of operations driven by a busy counter. It judges every read against a reference model of the two toggles that advances once per read edge.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_PROG  = 2'd1,
        M_ERASE = 2'd2,
        M_SUSP  = 2'd3
    } mode_e;

    typedef struct packed {
        logic flip6;
        logic flip2;
    } tog_s;

    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;
    localparam int REG_POS  = 2;

    function automatic mode_e pick_mode(input logic busy_i,
                                        input logic erase_i,
                                        input logic susp_i);
        if (busy_i)      return erase_i ? M_ERASE : M_PROG;
        else if (susp_i) return M_SUSP;
        else             return M_IDLE;
    endfunction

endpackage

// File: rtl/wsg_strobe_edge.sv
module wsg_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb;
    end

    assign rise = stb & ~stb_q;

    // R10: a strobe held high yields one edge only
    assert_single_edge_R10: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/wsg_region_match.sv
module wsg_region_match #(
    parameter int AW       = 20,
    parameter int SECT_LSB = 11
) (
    input  logic          susp,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] susp_addr,
    output logic          hit
);
    localparam int TAGW = AW - SECT_LSB;

    logic [TAGW-1:0] rd_tag, sp_tag;

    assign rd_tag = rd_addr[AW-1:SECT_LSB];
    assign sp_tag = susp_addr[AW-1:SECT_LSB];
    assign hit    = susp && (rd_tag == sp_tag);
endmodule

// File: rtl/wsg_toggle_state.sv
module wsg_toggle_state
    import wsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  mode_e mode,
    input  logic  hit,
    output tog_s  tog
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tog <= '0;
        end else if (mode == M_IDLE) begin
            tog <= '0;
        end else if (rise) begin
            case (mode)
                M_PROG:  tog.flip6 <= ~tog.flip6;
                M_ERASE: begin
                    tog.flip6 <= ~tog.flip6;
                    tog.flip2 <= ~tog.flip2;
                end
                M_SUSP:  if (hit) tog.flip2 <= ~tog.flip2;
                default: ;
            endcase
        end
    end

    // R5: each busy read inverts the bit-6 toggle
    assert_busy_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (rise && (mode == M_PROG || mode == M_ERASE)) |=> (tog.flip6 != $past(tog.flip6)));

    // R6: a program read never advances the bit-2 toggle
    assert_prog_hold2_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PROG) |=> $stable(tog.flip2));

    // R8: out-of-region reads while suspended leave the toggles alone
    assert_miss_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == M_SUSP && !hit) |=> $stable(tog));

    // R11: idle clears the toggles
    assert_idle_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == M_IDLE) |=> (tog == '0));
endmodule

// File: rtl/write_status_gen.sv
module write_status_gen
    import wsg_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 20,
    parameter int SECT_LSB = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          busy,
    input  logic          op_erase,
    input  logic [DW-1:0] pgm_data,
    input  logic          erase_susp,
    input  logic [AW-1:0] susp_addr,
    output logic [DW-1:0] status_q
);
    mode_e          mode;
    logic           rise;
    logic           hit;
    tog_s           tog;
    logic [DW-1:0]  word;

    assign mode = pick_mode(busy, op_erase, erase_susp);

    wsg_strobe_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .stb  (rd_stb),
        .rise (rise)
    );

    wsg_region_match #(.AW(AW), .SECT_LSB(SECT_LSB)) u_region (
        .susp      (erase_susp),
        .rd_addr   (rd_addr),
        .susp_addr (susp_addr),
        .hit       (hit)
    );

    wsg_toggle_state u_tog (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .mode (mode),
        .hit  (hit),
        .tog  (tog)
    );

    always_comb begin
        word = '0;
        case (mode)
            M_IDLE: word = arr_data;
            M_PROG: begin
                word[POLL_POS] = ~pgm_data[POLL_POS];
                word[TOG_POS]  = tog.flip6;
            end
            M_ERASE: begin
                word[POLL_POS] = 1'b0;
                word[TOG_POS]  = tog.flip6;
                word[REG_POS]  = tog.flip2;
            end
            M_SUSP: begin
                if (hit) begin
                    word[POLL_POS] = 1'b1;
                    word[TOG_POS]  = 1'b1;
                    word[REG_POS]  = tog.flip2;
                end else begin
                    word = arr_data;
                end
            end
            default: word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       status_q <= '0;
        else if (rise) status_q <= word;
    end

    // R10: the returned word only moves on a read edge
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(status_q));

    // R2: idle reads pass the array word
    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (rise && !busy && !erase_susp) |=> (status_q == $past(arr_data)));

    // R3: program poll bit is the inverted write bit
    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (rst)
        (rise && busy && !op_erase) |=> (status_q[POLL_POS] == !$past(pgm_data[POLL_POS])));

    // R4: erase poll bit reads low
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (rst)
        (rise && busy && op_erase) |=> !status_q[POLL_POS]);

    // R7: in-region suspended reads show bits 7 and 6 high
    assert_susp_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (rise && !busy && hit) |=> (status_q[POLL_POS] && status_q[TOG_POS]));
endmodule

// File: tb/sim_write_status_gen.sv
module sim_write_status_gen;
    localparam int DW = 16;
    localparam int AW = 20;
    localparam int SL = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic          busy = 1'b0;
    logic          op_erase = 1'b0;
    logic [DW-1:0] pgm_data = '0;
    logic          erase_susp = 1'b0;
    logic [AW-1:0] susp_addr = '0;
    logic [DW-1:0] status_q;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic mt6 = 1'b0;
    logic mt2 = 1'b0;

    always #2 clk = ~clk;

    write_status_gen #(.DW(DW), .AW(AW), .SECT_LSB(SL)) u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .arr_data(arr_data), .busy(busy), .op_erase(op_erase),
        .pgm_data(pgm_data), .erase_susp(erase_susp),
        .susp_addr(susp_addr), .status_q(status_q)
    );

    function automatic logic m_hit(input logic su, input logic [AW-1:0] sa,
                                   input logic [AW-1:0] ra);
        return su && (ra[AW-1:SL] == sa[AW-1:SL]);
    endfunction

    function automatic logic [DW-1:0] m_word(input logic b, input logic er,
            input logic su, input logic h, input logic [DW-1:0] ad,
            input logic [DW-1:0] pd);
        logic [DW-1:0] w;
        w = '0;
        if (b && !er)      begin w[7] = ~pd[7]; w[6] = mt6; end
        else if (b)        begin w[6] = mt6; w[2] = mt2; end
        else if (su && h)  begin w[7] = 1'b1; w[6] = 1'b1; w[2] = mt2; end
        else               w = ad;
        return w;
    endfunction

    function automatic string m_tag(input logic b, input logic er,
                                    input logic su, input logic h);
        if (b && !er) return su ? "R9" : "R3";
        if (b)        return "R4";
        if (su)       return h ? "R7" : "R8";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic b, input logic er, input logic su,
            input logic [AW-1:0] sa, input logic [AW-1:0] ra,
            input logic [DW-1:0] ad, input logic [DW-1:0] pd,
            input string tag, input int hold);
        logic [DW-1:0] exp;
        logic h;
        string t;
        @(negedge clk);
        busy = b; op_erase = er; erase_susp = su; susp_addr = sa;
        rd_addr = ra; arr_data = ad; pgm_data = pd;
        h = m_hit(su, sa, ra);
        exp = m_word(b, er, su, h, ad, pd);
        t = (tag == "") ? m_tag(b, er, su, h) : tag;
        if (!b && !su)    begin mt6 = 1'b0; mt2 = 1'b0; end
        else if (b && !er) mt6 = ~mt6;
        else if (b)       begin mt6 = ~mt6; mt2 = ~mt2; end
        else if (h)       mt2 = ~mt2;
        rd_stb = 1'b1;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(t, status_q, exp);
        end
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    logic [AW-1:0] sreg;
    logic [DW-1:0] held;

    initial begin
        int cnt, saved;
        logic op, su;
        logic [AW-1:0] sa, ra;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", status_q, '0);

        do_read(0, 0, 0, '0, 20'h00123, 16'hA5C3, '0, "R2", 1);
        // program, three reads: bit6 0,1,0 from cleared state, bit2 0
        do_read(1, 0, 0, '0, 20'h00010, 16'hFFFF, 16'h0080, "R1", 1);
        do_read(1, 0, 0, '0, 20'h00010, 16'hFFFF, 16'h0080, "R5", 1);
        do_read(1, 0, 0, '0, 20'h00010, 16'hFFFF, 16'h0000, "R6", 1);
        // completion edge: busy falls with the read
        do_read(0, 0, 0, '0, 20'h00010, 16'h1234, '0, "R11", 1);
        // erase: bit2 and bit6 alternate
        for (int i = 0; i < 4; i++)
            do_read(1, 1, 0, '0, 20'h04000, 16'hFFFF, '0, "R6", 1);
        // suspend inside region 0x04000
        sreg = 20'h04000;
        do_read(0, 1, 1, sreg, 20'h04155, 16'h5555, '0, "R7", 1);
        do_read(0, 1, 1, sreg, 20'h80000, 16'h3C3C, '0, "R8", 1);
        do_read(0, 1, 1, sreg, 20'h047FF, 16'h5555, '0, "R8", 1);
        // program during suspend, read at suspended address
        do_read(1, 0, 1, sreg, 20'h04001, 16'h0000, 16'h007F, "R9", 1);
        do_read(1, 0, 1, sreg, 20'h90000, 16'h0000, 16'h007F, "R9", 1);
        // long strobe: one value, one advance
        do_read(1, 1, 0, '0, 20'h04000, 16'hFFFF, '0, "R10", 4);
        do_read(1, 1, 0, '0, 20'h04000, 16'hFFFF, '0, "R10", 1);
        // idle cycles with changing data do not move the output
        held = status_q;
        @(negedge clk); arr_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        check("R10", status_q, held);
        do_read(0, 0, 0, '0, 20'h0, 16'hC0DE, '0, "R11", 1);
        do_read(1, 1, 0, '0, 20'h0, 16'hFFFF, '0, "R11", 1);

        // random walk of operations driven by a busy counter
        cnt = 0; saved = 0; op = 1'b0; su = 1'b0; sa = '0;
        for (int i = 0; i < 400; i++) begin
            if (!su && cnt == 0 && $urandom_range(0, 2) == 0) begin
                cnt = $urandom_range(1, 6); op = 1'($urandom_range(0, 1));
            end else if (!su && cnt != 0 && op && $urandom_range(0, 4) == 0) begin
                su = 1'b1; saved = cnt; cnt = 0; sa = AW'($urandom);
            end else if (su && cnt == 0 && $urandom_range(0, 3) == 0) begin
                if ($urandom_range(0, 1) == 1) begin
                    cnt = saved; su = 1'b0; op = 1'b1;
                end else begin
                    cnt = $urandom_range(1, 3); op = 1'b0;
                end
            end
            if (su && cnt == 0) op = 1'b1;
            ra = ($urandom_range(0, 1) == 1) ?
                 {sa[AW-1:SL], SL'($urandom)} : AW'($urandom);
            do_read(cnt != 0, op, su, sa, ra, DW'($urandom), DW'($urandom),
                    "", $urandom_range(1, 2));
            if (cnt != 0) cnt--;
        end

        finished = 1'b1;
        finish_run();
    end
endmodule